// File: doc/BRIEF.md
# Shared PWM Waveform Generator Bank

A pool of eight waveform generators feeds 33 output channels. Channels 0 to 15 serve the direct pins and channels 16 to 32 serve the serially shifted pins; all of them draw on the same pool. Each generator has a programmable period and a programmable duty. A per-channel routing entry picks the generator that drives the channel, or leaves the channel low when its enable bit is clear. The generators have no on/off bit, so a duty of 0 is how a generator is switched off.

The `tick` input marks one phase step of the base time unit. Each period is split into 256 phase steps, and one step lasts P ticks, where P is the period value. With a tick every 4 ms / 256, P runs from 4 ms to 1 s. Settings are loaded through a one-cycle write port. A generator keeps its running settings until its current period completes, so a new setting never cuts a period short. Routing changes take effect on the next clock.

Top module: `pwm_gen_bank`

## Requirements
- R1: After reset every generator runs with period 1 and duty 0, its pending setting is the same, every routing entry is disabled, and all 33 outputs are low.
- R2: A write to address g (0 to 7) sets the pending setting of generator g: period in wr_data[7:0], duty in wr_data[15:8].
- R3: A generator copies its pending setting into its running setting only at the end of a period, which is the tick that moves the phase from 255 back to 0. Until then the output follows the old setting.
- R4: The phase of a generator advances by one step every P ticks, where P is its running period, so one period lasts 256*P ticks. Without a tick no phase or prescale state changes.
- R5: A generator output is high while its phase is less than its duty. Duty 255 holds the output high for the whole period, and duty 0 holds it low.
- R6: A generator write whose period field is 0 or above 250 is ignored as a whole, and the duty field of that write is ignored too.
- R7: A write to address 8+k sets the routing of channels 8k to 8k+7. Channel 8k+j uses wr_data[4j+3:4j], where bits [2:0] give the generator index and bit 3 is the enable. Channel 32 uses bits [3:0] of address 12. A channel whose enable is clear outputs low.
- R8: Routing changes show on pwm_out on the clock after the write. Any number of channels may share one generator and carry the same waveform.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| tick | input | 1 | One phase-step time unit |
| wr_en | input | 1 | Write strobe |
| wr_addr | input | 4 | 0-7 generator setting, 8-12 routing words |
| wr_data | input | 32 | Write data |
| pwm_out | output | 33 | Channel outputs, 0-15 direct, 16-32 serial |

## Verification
The hardest situation to reach is a new setting that is pending while a period is partly run, because the swap point depends on the running period and on every tick since the last wrap. The bench resets and holds tick low while it programs, then gives exactly 256 ticks so that every generator, still at period 1, wraps on the same edge and loads its setting. From that known phase 0 it counts ticks to place each generator on a chosen phase. To test the deferred update it writes new settings part way through a period and checks the output both before and after the next wrap.

// File: rtl/pwm_gen_bank.sv
module pwm_gen_bank #(
  parameter int NUM_GEN = 8,
  parameter int NUM_CH  = 33,
  parameter int PRD_MAX = 250
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tick,
  input  logic              wr_en,
  input  logic [3:0]        wr_addr,
  input  logic [31:0]       wr_data,
  output logic [NUM_CH-1:0] pwm_out
);
  localparam int IDX_W = $clog2(NUM_GEN);

  logic [7:0]       act_prd  [NUM_GEN];
  logic [7:0]       act_duty [NUM_GEN];
  logic [7:0]       pnd_prd  [NUM_GEN];
  logic [7:0]       pnd_duty [NUM_GEN];
  logic [7:0]       pre      [NUM_GEN];
  logic [7:0]       phase    [NUM_GEN];
  logic [NUM_GEN-1:0] gen_out;
  logic [NUM_GEN-1:0] step;
  logic [NUM_GEN-1:0] wrap;

  logic [IDX_W-1:0] map_sel [NUM_CH];
  logic [NUM_CH-1:0] map_en;

  wire prd_ok = (wr_data[7:0] != 8'd0) && (wr_data[7:0] <= 8'(PRD_MAX));

  for (genvar g = 0; g < NUM_GEN; g++) begin : g_gen
    localparam logic [3:0] GA = 4'(g);

    assign step[g]    = tick && (pre[g] == act_prd[g] - 8'd1);
    assign wrap[g]    = step[g] && (phase[g] == 8'hFF);
    assign gen_out[g] = (act_duty[g] == 8'hFF) || (phase[g] < act_duty[g]);

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        pnd_prd[g]  <= 8'd1;
        pnd_duty[g] <= 8'd0;
      end else if (wr_en && wr_addr == GA && prd_ok) begin
        pnd_prd[g]  <= wr_data[7:0];
        pnd_duty[g] <= wr_data[15:8];
      end
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        act_prd[g]  <= 8'd1;
        act_duty[g] <= 8'd0;
        pre[g]      <= 8'd0;
        phase[g]    <= 8'd0;
      end else if (tick) begin
        if (step[g]) begin
          pre[g]   <= 8'd0;
          phase[g] <= phase[g] + 8'd1;
          if (wrap[g]) begin
            act_prd[g]  <= pnd_prd[g];
            act_duty[g] <= pnd_duty[g];
          end
        end else begin
          pre[g] <= pre[g] + 8'd1;
        end
      end
    end

    a_r4_no_tick_hold: assert property (@(posedge clk) disable iff (!rst_n)
      !tick |=> $stable(phase[g]) && $stable(pre[g]));
    a_r4_pre_bound: assert property (@(posedge clk) disable iff (!rst_n)
      pre[g] < act_prd[g]);
    a_r3_hold_mid_period: assert property (@(posedge clk) disable iff (!rst_n)
      !wrap[g] |=> $stable(act_prd[g]) && $stable(act_duty[g]));
    a_r3_load_at_wrap: assert property (@(posedge clk) disable iff (!rst_n)
      wrap[g] |=> phase[g] == 8'd0 && act_duty[g] == $past(pnd_duty[g])
                  && act_prd[g] == $past(pnd_prd[g]));
    a_r6_period_range: assert property (@(posedge clk) disable iff (!rst_n)
      pnd_prd[g] != 8'd0 && pnd_prd[g] <= 8'(PRD_MAX));
    a_r5_zero_low: assert property (@(posedge clk) disable iff (!rst_n)
      act_duty[g] == 8'd0 |-> !gen_out[g]);
  end

  for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
    localparam logic [3:0] MA = 4'(NUM_GEN + c / 8);
    localparam int         LB = 4 * (c % 8);

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        map_sel[c] <= '0;
        map_en[c]  <= 1'b0;
      end else if (wr_en && wr_addr == MA) begin
        map_sel[c] <= wr_data[LB +: IDX_W];
        map_en[c]  <= wr_data[LB + 3];
      end
    end

    assign pwm_out[c] = map_en[c] && gen_out[map_sel[c]];

    a_r7_disabled_low: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && wr_addr == MA && !wr_data[LB + 3]) |=> !pwm_out[c]);
  end
endmodule

// File: tb/pwm_gen_bank_tb.sv
module pwm_gen_bank_tb;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        tick = 1'b0;
  logic        wr_en = 1'b0;
  logic [3:0]  wr_addr = '0;
  logic [31:0] wr_data = '0;
  logic [32:0] pwm_out;

  int n_cmp = 0;
  int n_bad = 0;
  bit done = 1'b0;

  pwm_gen_bank u_dut (
    .clk(clk), .rst_n(rst_n), .tick(tick), .wr_en(wr_en),
    .wr_addr(wr_addr), .wr_data(wr_data), .pwm_out(pwm_out)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  // rows: period, duty, ticks after load, expected out[0]
  localparam int unsigned VEC [9][4] = '{
    '{1, 0, 0, 0}, '{1, 255, 255, 1}, '{1, 128, 127, 1},
    '{1, 128, 128, 0}, '{2, 10, 19, 1}, '{2, 10, 20, 0},
    '{250, 1, 249, 1}, '{250, 1, 250, 0}, '{3, 255, 600, 1}
  };

  task automatic check(input logic act, input logic exp, input string req);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: got %b expected %b", req, act, exp);
    end
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0;
    tick = 1'b0;
    wr_en = 1'b0;
    @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
  endtask

  task automatic wr(input logic [3:0] a, input logic [31:0] d);
    wr_en = 1'b1;
    wr_addr = a;
    wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic ticks(input int n);
    if (n > 0) begin
      tick = 1'b1;
      repeat (n) @(negedge clk);
      tick = 1'b0;
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_cmp++;
      n_bad++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin
    do_reset();
    // R1: all outputs low after reset
    check(|pwm_out, 1'b0, "R1 reset low");
    ticks(300);
    check(|pwm_out, 1'b0, "R1 reset low after ticks");

    // Vector table: R2 R4 R5 with gen0 on ch0
    for (int i = 0; i < 9; i++) begin
      do_reset();
      wr(4'd0, {16'd0, 8'(VEC[i][1]), 8'(VEC[i][0])});
      wr(4'd8, 32'h0000_0008);
      ticks(256);
      ticks(int'(VEC[i][2]));
      check(pwm_out[0], 1'(VEC[i][3]), $sformatf("R5 R4 vector %0d", i));
    end

    // R3: deferred update
    do_reset();
    wr(4'd0, 32'h0000_FF01);
    wr(4'd8, 32'h0000_0008);
    ticks(256);
    check(pwm_out[0], 1'b1, "R3 loaded at wrap");
    wr(4'd0, 32'h0000_0001);
    ticks(10);
    check(pwm_out[0], 1'b1, "R3 old duty kept mid period");
    ticks(245);
    check(pwm_out[0], 1'b1, "R3 old duty kept at phase 255");
    ticks(1);
    check(pwm_out[0], 1'b0, "R3 new duty after wrap");

    // R4: no tick, no progress
    do_reset();
    wr(4'd0, 32'h0000_0501);
    wr(4'd8, 32'h0000_0008);
    ticks(256);
    ticks(4);
    repeat (20) @(negedge clk);
    check(pwm_out[0], 1'b1, "R4 phase held without tick");
    ticks(1);
    check(pwm_out[0], 1'b0, "R4 phase resumes with tick");

    // R6: out of range period ignored, duty too
    do_reset();
    wr(4'd1, 32'h0000_FF00);
    wr(4'd2, 32'h0000_FFFB);
    wr(4'd8, 32'h0000_0A90);
    ticks(256);
    check(pwm_out[1], 1'b0, "R6 period 0 write ignored");
    check(pwm_out[2], 1'b0, "R6 period 251 write ignored");
    ticks(256);
    check(pwm_out[1] | pwm_out[2], 1'b0, "R6 still ignored next period");

    // R7 R8: routing, serial range, disable, sharing
    do_reset();
    wr(4'd3, 32'h0000_FF02);
    ticks(512);
    check(pwm_out[32], 1'b0, "R7 ch32 not yet mapped");
    wr(4'd12, 32'hFFFF_FFFB);
    check(pwm_out[32], 1'b1, "R8 ch32 mapped immediately");
    wr(4'd10, 32'h0000_000B);
    wr(4'd9,  32'hB000_0003);
    check(pwm_out[16], 1'b1, "R8 ch16 shares gen3");
    check(pwm_out[15], 1'b1, "R7 ch15 direct pin on gen3");
    check(pwm_out[8], 1'b0, "R7 ch8 enable clear low");
    check(|pwm_out[31:17], 1'b0, "R7 unmapped serial channels low");
    wr(4'd12, 32'h0000_0003);
    check(pwm_out[32], 1'b0, "R7 ch32 disabled low");

    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule